// File: doc/BRIEF.md
# Interleaved I/Q CIC Decimator

This block is a three-stage cascaded integrator-comb decimation filter. It takes the in-phase and quadrature streams from a digital down-converter through a single shared datapath, so that one filter serves both channels. The input is one sample per accepted cycle. A channel tag marks each sample as I or Q, and the two channels alternate. Each integrator and each comb delay keeps a separate register for each channel, so the two histories never mix. The datapath uses only adders, subtractors and registers.

The integrators update on every accepted sample. A pair counter selects one I/Q pair out of every M pairs, where M is the runtime decimation factor. Only the selected samples enter the comb section, which therefore runs at the reduced rate. Each stage keeps only the most significant bits it needs. The stage widths are parameters, and the default set (28, 23, 18 / 16, 15, 14) suits a 10-bit input with factors up to 64. The result is a 14-bit tagged output stream.

Top module: `iq_cic_decim`

## Requirements
- R1: While rst_ni is low, and after it is released, every integrator, comb delay and the pair counter are zero and out_valid_o, out_ch_o and out_data_o are 0.
- R2: On an accepted sample of channel c (in_valid_i=1, in_ch_i=c, where 0 is I and 1 is Q), stage 1 adds the sign-extended input to its channel-c register. Stage k>1 adds the value stage k-1 held for channel c before this update. All of this is two's-complement arithmetic that wraps within each stage's width.
- R3: Each stage takes the upper STAGE_W[k] bits of the preceding stage and drops the lower bits by truncation. This applies integrator to integrator, last integrator to first comb, and comb to comb.
- R4: Each comb stage outputs its input minus the input it last received for the same channel, which is a differential delay of one decimated sample. A comb stage updates only on kept samples.
- R5: A pair counter advances on each accepted Q sample. A pair is kept when the counter is at least dec_i-1, and the Q sample of a kept pair returns the counter to 0. dec_i=0 acts as 1, and values above DEC_MAX act as DEC_MAX. After reset, the first pair kept is pair number M-1, counting from 0.
- R6: A sample of one channel changes none of the state of the other channel. A channel fed with zeros produces only zero outputs.
- R7: A kept sample accepted at one rising edge makes out_valid_o high for exactly one cycle after the second rising edge. out_ch_o carries the sample's tag at that point.
- R8: Cycles with in_valid_i low change no filter state and no counter.
- R9: With the default widths, a constant full-scale input settles to about in*M^3/2^14 when M=64. This holds even though the integrators wrap many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dec_i | input | $clog2(DEC_MAX+1) | Decimation factor M |
| in_valid_i | input | 1 | Input sample strobe |
| in_ch_i | input | 1 | Input channel tag, 0 = I, 1 = Q |
| in_data_i | input | IN_W | Signed input sample |
| out_valid_o | output | 1 | Output sample strobe |
| out_ch_o | output | 1 | Output channel tag |
| out_data_o | output | STAGE_W[2*NSTG-1] | Signed decimated sample |

## Verification
An accepted sample reaches the integrators at its own edge. A kept sample passes through the combs and appears on the output register one edge later, so its result is due at the second rising edge after acceptance. The bench drives inputs on falling edges and keeps a two-entry pipeline of expected results from its own model. At each falling edge it compares out_valid_o, and on a valid cycle also out_ch_o and out_data_o, against the entry that has just come due. This means an early, late, missing or extra output is caught in the exact cycle it occurs.

// File: rtl/cic_pkg.sv
package cic_pkg;
  typedef enum logic {CH_I = 1'b0, CH_Q = 1'b1} iq_ch_e;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/cic_dec_ctrl.sv
module cic_dec_ctrl #(
  parameter int unsigned DEC_MAX = 64,
  parameter int unsigned DEC_W   = $clog2(DEC_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEC_W-1:0] dec_i,
  input  logic             adv_i,
  output logic             keep_o
);
  localparam int unsigned CNT_W = $clog2(DEC_MAX);

  logic [CNT_W-1:0] cnt_q, lim;

  // factor 0 behaves as 1, oversized factors saturate
  always_comb begin
    if (dec_i == '0)                         lim = '0;
    else if (dec_i > DEC_W'(DEC_MAX))        lim = CNT_W'(DEC_MAX - 1);
    else                                     lim = CNT_W'(dec_i - DEC_W'(1));
  end

  assign keep_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (adv_i)  cnt_q <= keep_o ? '0 : cnt_q + CNT_W'(1);
  end

  a_r5_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEC_MAX - 1));
  a_r5_wrap_on_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && keep_o |=> cnt_q == '0);
  a_r8_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_q));
endmodule

// File: rtl/cic_integ_stage.sv
module cic_integ_stage #(
  parameter int unsigned W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ch_i,
  input  logic [W-1:0]      x_i,
  output logic [1:0][W-1:0] acc_o
);
  logic [1:0][W-1:0] acc_q;

  // wrap-around accumulate, one register per channel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (en_i)  acc_q[ch_i] <= acc_q[ch_i] + x_i;
  end

  assign acc_o = acc_q;

  a_r8_int_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));
  a_r6_int_i_keeps_q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !ch_i |=> $stable(acc_q[1]));
  a_r6_int_q_keeps_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ch_i |=> $stable(acc_q[0]));
endmodule

// File: rtl/cic_comb_stage.sv
module cic_comb_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         ch_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  logic [1:0][W-1:0] dly_q;

  assign y_o = x_i - dly_q[ch_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dly_q <= '0;
    else if (en_i)  dly_q[ch_i] <= x_i;
  end

  a_r4_dly_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> dly_q[$past(ch_i)] == $past(x_i));
  a_r8_dly_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(dly_q));
endmodule

// File: rtl/iq_cic_decim.sv
module iq_cic_decim
  import cic_pkg::*;
#(
  parameter int unsigned IN_W    = 10,
  parameter int unsigned DEC_MAX = 64,
  parameter int unsigned NSTG    = 3,
  parameter int unsigned STAGE_W [2*NSTG] = '{28, 23, 18, 16, 15, 14},
  localparam int unsigned DEC_W  = $clog2(DEC_MAX + 1),
  localparam int unsigned OUT_W  = STAGE_W[2*NSTG-1]
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEC_W-1:0] dec_i,
  input  logic             in_valid_i,
  input  logic             in_ch_i,
  input  logic [IN_W-1:0]  in_data_i,
  output logic             out_valid_o,
  output logic             out_ch_o,
  output logic [OUT_W-1:0] out_data_o
);
  localparam int unsigned WMAX = STAGE_W[0];

  logic keep, adv, keep_d, ch_d;
  logic [NUM_CH-1:0][WMAX-1:0] int_lj [NSTG];
  logic [WMAX-1:0]             comb_lj [NSTG];

  assign adv = in_valid_i && (iq_ch_e'(in_ch_i) == CH_Q);

  cic_dec_ctrl #(.DEC_MAX(DEC_MAX), .DEC_W(DEC_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (dec_i),
    .adv_i  (adv),
    .keep_o (keep)
  );

  // integrator chain at input rate; stage outputs kept MSB-aligned
  for (genvar k = 0; k < NSTG; k++) begin : g_int
    localparam int unsigned W = STAGE_W[k];
    logic [W-1:0]              x;
    logic [NUM_CH-1:0][W-1:0]  acc;

    if (k == 0) begin : g_first
      assign x = {{(W - IN_W){in_data_i[IN_W-1]}}, in_data_i};
    end else begin : g_next
      assign x = int_lj[k-1][in_ch_i][WMAX-1 -: W];
    end

    cic_integ_stage #(.W(W)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (in_valid_i),
      .ch_i   (in_ch_i),
      .x_i    (x),
      .acc_o  (acc)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lj
      if (W == WMAX) begin : g_full
        assign int_lj[k][c] = acc[c];
      end else begin : g_pad
        assign int_lj[k][c] = {acc[c], {(WMAX - W){1'b0}}};
      end
    end
  end

  // decimated sample enters combs one cycle after acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_d <= 1'b0;
      ch_d   <= 1'b0;
    end else begin
      keep_d <= in_valid_i && keep;
      ch_d   <= in_ch_i;
    end
  end

  for (genvar k = 0; k < NSTG; k++) begin : g_comb
    localparam int unsigned W = STAGE_W[NSTG + k];
    logic [W-1:0] x, y;

    if (k == 0) begin : g_first
      assign x = int_lj[NSTG-1][ch_d][WMAX-1 -: W];
    end else begin : g_next
      assign x = comb_lj[k-1][WMAX-1 -: W];
    end

    cic_comb_stage #(.W(W)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (keep_d),
      .ch_i   (ch_d),
      .x_i    (x),
      .y_o    (y)
    );

    if (W == WMAX) begin : g_full
      assign comb_lj[k] = y;
    end else begin : g_pad
      assign comb_lj[k] = {y, {(WMAX - W){1'b0}}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_ch_o    <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= keep_d;
      out_ch_o    <= ch_d;
      if (keep_d) out_data_o <= comb_lj[NSTG-1][WMAX-1 -: OUT_W];
    end
  end

  a_r7_out_needs_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i, 2));
  a_r7_out_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_ch_o == $past(in_ch_i, 2));
  a_r7_no_idle_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ##1 !out_valid_o);
endmodule

// File: tb/test_iq_cic_decim.sv
module test_iq_cic_decim;
  localparam int CLK_P   = 10;
  localparam int IN_W    = 10;
  localparam int DEC_MAX = 64;
  localparam int DEC_W   = $clog2(DEC_MAX + 1);
  localparam int W0 = 28, W1 = 23, W2 = 18, W3 = 16, W4 = 15, W5 = 14;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DEC_W-1:0] dec = DEC_W'(4);
  logic             in_valid = 1'b0;
  logic             in_ch = 1'b0;
  logic [IN_W-1:0]  in_data = '0;
  logic             out_valid;
  logic             out_ch;
  logic [W5-1:0]    out_data;

  int n_chk = 0;
  int n_err = 0;
  string cur_tag = "R2";

  longint m_i1 [2], m_i2 [2], m_i3 [2], m_d1 [2], m_d2 [2], m_d3 [2];
  int     m_cnt;
  bit     e1_v, e1_ch, e2_v, e2_ch;
  longint e1_d, e2_d;
  int     n_out [2];
  longint last_out [2];
  int     n_nonzero [2];

  iq_cic_decim i_iq_cic_decim (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .dec_i       (dec),
    .in_valid_i  (in_valid),
    .in_ch_i     (in_ch),
    .in_data_i   (in_data),
    .out_valid_o (out_valid),
    .out_ch_o    (out_ch),
    .out_data_o  (out_data)
  );

  always #(CLK_P / 2) clk = ~clk;

  function automatic longint sx(longint v, int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  task automatic check(string tag, longint act, longint exp, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_i1[c] = 0; m_i2[c] = 0; m_i3[c] = 0;
      m_d1[c] = 0; m_d2[c] = 0; m_d3[c] = 0;
    end
    m_cnt = 0;
    e1_v = 0; e2_v = 0;
  endtask

  task automatic stats_clear();
    for (int c = 0; c < 2; c++) begin
      n_out[c] = 0; last_out[c] = 0; n_nonzero[c] = 0;
    end
  endtask

  // one cycle: check the result due now, then drive and model the next input
  task automatic step(bit v, bit ch, int d);
    longint x, o1, o2, y, c1, c2, c3;
    int lim;
    bit keep;
    @(negedge clk);
    check("R7", longint'(out_valid), longint'(e2_v), "out_valid_o");
    if (e2_v && out_valid) begin
      check("R7", longint'(out_ch), longint'(e2_ch), "out_ch_o");
      check(cur_tag, sx(longint'(out_data), W5), e2_d, "out_data_o");
      n_out[out_ch]++;
      last_out[out_ch] = sx(longint'(out_data), W5);
      if (out_data != '0) n_nonzero[out_ch]++;
    end
    e2_v = e1_v; e2_ch = e1_ch; e2_d = e1_d;
    in_valid = v; in_ch = ch; in_data = IN_W'(d);
    e1_v = 0;
    if (v) begin
      lim = (dec == 0) ? 0 : ((int'(dec) > DEC_MAX) ? DEC_MAX - 1 : int'(dec) - 1);
      keep = (m_cnt >= lim);
      o1 = m_i1[ch]; o2 = m_i2[ch];
      m_i1[ch] = sx(o1 + sx(longint'(d), IN_W), W0);
      m_i2[ch] = sx(o2 + (o1 >>> (W0 - W1)), W1);
      m_i3[ch] = sx(m_i3[ch] + (o2 >>> (W1 - W2)), W2);
      if (keep) begin
        x  = m_i3[ch] >>> (W2 - W3);
        c1 = sx(x - m_d1[ch], W3); m_d1[ch] = x;
        y  = c1 >>> (W3 - W4);
        c2 = sx(y - m_d2[ch], W4); m_d2[ch] = y;
        y  = c2 >>> (W4 - W5);
        c3 = sx(y - m_d3[ch], W5); m_d3[ch] = y;
        e1_v = 1; e1_ch = ch; e1_d = c3;
      end
      if (ch) m_cnt = keep ? 0 : m_cnt + 1;
    end
  endtask

  task automatic pair(int di, int dq);
    step(1, 0, di);
    step(1, 1, dq);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    model_clear();
    repeat (2) @(negedge clk);
    check("R1", longint'(out_valid), 0, "out_valid_o in reset");
    check("R1", longint'(out_ch), 0, "out_ch_o in reset");
    check("R1", longint'(out_data), 0, "out_data_o in reset");
    rst_n = 1;
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check("R1", longint'(out_valid), 0, "out_valid_o after reset");
    check("R1", longint'(out_data), 0, "out_data_o after reset");
  endtask

  // R2 R3 R4: step response of both channels, factor 4
  task automatic t_step_response();
    cur_tag = "R4"; dec = DEC_W'(4); stats_clear();
    for (int i = 0; i < 40; i++) pair(100, -50);
    drain();
    check("R5", n_out[0], 10, "I outputs for 40 pairs at M=4");
    check("R5", n_out[1], 10, "Q outputs for 40 pairs at M=4");
  endtask

  // R5: factor selection including 0, 1 and saturation
  task automatic t_dec_select();
    cur_tag = "R5";
    do_reset(); dec = DEC_W'(1); stats_clear();
    for (int i = 0; i < 8; i++) pair(i * 7 - 20, 30 - i);
    drain();
    check("R5", n_out[0], 8, "I outputs at M=1");
    check("R5", n_out[1], 8, "Q outputs at M=1");
    do_reset(); dec = '0; stats_clear();
    for (int i = 0; i < 6; i++) pair(5, -5);
    drain();
    check("R5", n_out[0], 6, "I outputs at dec_i=0");
    do_reset(); dec = DEC_W'(100); stats_clear();
    for (int i = 0; i < 130; i++) pair(3, 2);
    drain();
    check("R5", n_out[0], 2, "I outputs for 130 pairs saturated to 64");
    check("R5", n_out[1], 2, "Q outputs for 130 pairs saturated to 64");
    do_reset(); dec = DEC_W'(5); stats_clear();
    for (int i = 0; i < 4; i++) pair(9, 9);
    drain();
    check("R5", n_out[0], 0, "no output before pair M-1");
    pair(9, 9); drain();
    check("R5", n_out[0], 1, "first output at pair M-1");
  endtask

  // R6: Q fed zeros while I carries a varying pattern
  task automatic t_isolation();
    logic [15:0] lfsr = 16'hACE1;
    cur_tag = "R6";
    do_reset(); dec = DEC_W'(5); stats_clear();
    for (int i = 0; i < 50; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pair(int'($signed(lfsr[9:0])), 0);
    end
    drain();
    check("R6", n_nonzero[1], 0, "nonzero Q outputs with zero Q input");
    check("R6", n_out[1], 10, "Q outputs still produced");
    check("R6", longint'(n_nonzero[0] > 0), 1, "I outputs carry signal");
  endtask

  // R8: idle cycles between samples and between pair halves
  task automatic t_gaps();
    cur_tag = "R8";
    do_reset(); dec = DEC_W'(3); stats_clear();
    for (int i = 0; i < 24; i++) begin
      step(1, 0, 40 + i);
      for (int g = 0; g < (i % 3); g++) step(0, 1, 511);
      step(1, 1, -i);
      step(0, 0, -300);
    end
    drain();
    check("R8", n_out[0], 8, "I outputs with gaps at M=3");
    check("R8", n_out[1], 8, "Q outputs with gaps at M=3");
  endtask

  // R9: full-scale constant input at M=64, integrators wrap
  task automatic t_full_scale();
    cur_tag = "R9";
    do_reset(); dec = DEC_W'(64); stats_clear();
    for (int i = 0; i < 6 * 64; i++) pair(511, -500);
    drain();
    check("R9", n_out[0], 6, "I outputs at M=64");
    check("R9", longint'(last_out[0] >= 8100 && last_out[0] <= 8191), 1, "I steady level in range");
    check("R9", longint'(last_out[1] >= -8100 && last_out[1] <= -7900), 1, "Q steady level in range");
  endtask

  // R1: reset mid-run clears all history
  task automatic t_reset_mid();
    cur_tag = "R1";
    dec = DEC_W'(2); stats_clear();
    for (int i = 0; i < 9; i++) pair(300, -300);
    do_reset(); stats_clear();
    for (int i = 0; i < 8; i++) pair(0, 0);
    drain();
    check("R1", n_out[0] + n_out[1], 8, "outputs after mid-run reset");
    check("R1", n_nonzero[0] + n_nonzero[1], 0, "nonzero outputs from cleared state");
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL R7 watchdog actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    model_clear();
    stats_clear();
    t_reset_state();
    t_step_response();
    t_dec_select();
    t_isolation();
    t_gaps();
    t_full_scale();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule